// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block keeps three 32-bit up-counters for measuring a core's behaviour: one counts clock cycles, the other two count pulses of events chosen from an event input vector. A single control register starts and stops counting, chooses the events, zeroes the counters, enables the overflow interrupt per counter and holds the sticky overflow flags. Software reaches the four registers through a one-request-per-cycle read/write port with a 2-bit register index. Each request gets a registered response one cycle later.

Each access is checked against the requester's privilege. Privileged requests always act. An unprivileged request acts only when the user-access validation input is high. Otherwise it is refused with an undefined-instruction indication. Event counting stops while the core is in debug state or while non-invasive debug is not allowed. A mirror of the raw event vector is driven out for external trace logic when export is enabled and the core is not in debug state.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset all four registers read 0, `irq` is 0, `evt_bus` is 0 and `rsp_valid` is 0.
- R2: Register index 0 is control, 1 the cycle counter, 2 event counter A and 3 event counter B. Every request is answered on the cycle after the edge that takes it. A granted read returns the register value from before that edge. A write or a refused request returns 0. Control bits 1, 2, 7 and 31:28 read as 0.
- R3: Control bit 0 is the enable. The first increment is taken at the third clock edge after the edge that writes the enable to 1. The edge that writes it to 0 still counts, and no later edge does.
- R4: With control bit 3 set, the cycle counter advances on every 64th counting edge instead of every counting edge. The divider phase starts from 0 after reset or a cycle-counter clear.
- R5: Writing control with bit 2 set zeroes the cycle counter and the divider phase. Writing control with bit 1 set zeroes both event counters. Neither bit is stored.
- R6: Event counter A counts edges where the event vector bit indexed by control bits 27:20 is high. Counter B does the same using bits 19:12. An index at or beyond the vector width selects no event.
- R7: The event counters hold while `dbg_state` is 1 or `dbg_permit` is 0. The cycle counter is not affected by either input.
- R8: An increment from all ones wraps to 0 and sets that counter's overflow flag. The flags sit at control bits 8 (cycle), 9 (A) and 10 (B). `irq` is the OR over counters of flag AND enable, with the enables at bits 4, 5 and 6 in the same order.
- R9: Writing 1 to a flag bit clears it only if the stored enable bit is 1 when the write is taken. A flag set in the same cycle survives the clear.
- R10: `evt_bus` equals `evt_in` when control bit 11 is 1 and `dbg_state` is 0. Otherwise it is 0.
- R11: A request with `acc_priv`=0 and `user_ok`=0 returns `rsp_undef`=1 and changes no register. A privileged request, or one made with `user_ok`=1, returns `rsp_undef`=0.
- R12: A granted write to a counter on an edge where that counter would also increment loads the written value, and the increment is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Register request this cycle |
| acc_write | input | 1 | 1 write, 0 read |
| acc_sel | input | 2 | Register index |
| acc_wdata | input | 32 | Write data |
| acc_priv | input | 1 | Requester is privileged |
| user_ok | input | 1 | Unprivileged access allowed |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data, 0 for writes and refusals |
| rsp_undef | output | 1 | Request refused |
| evt_in | input | NUM_EVT | Raw event pulses |
| dbg_state | input | 1 | Core is in debug state |
| dbg_permit | input | 1 | Non-invasive debug allowed |
| evt_bus | output | NUM_EVT | Exported event mirror |
| irq | output | 1 | Overflow interrupt |

## Verification
A response is due at the falling edge right after the rising edge that takes the request. The scoreboard monitor checks every response there, in request order. Counter results are never sampled while counting runs. Each counting window opens and closes with control writes. With the three-edge start latency and the counting closing edge, a window with m idle cycles between the two writes adds exactly m. Counters are read back only once they are stopped. `irq` and `evt_bus` follow stored state and inputs directly, so they are checked half a cycle after the write or input change that moves them.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int DATA_W  = 32;
  localparam int NUM_CTR = 3;
  localparam int SEL_W   = 8;

  localparam int B_EN    = 0;
  localparam int B_EVRST = 1;
  localparam int B_CYRST = 2;
  localparam int B_DIV   = 3;
  localparam int B_IE    = 4;
  localparam int B_FLAG  = 8;
  localparam int B_EXP   = 11;
  localparam int B_SEL1  = 12;
  localparam int B_SEL0  = 20;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CYC  = 2'd1,
    SEL_EVA  = 2'd2,
    SEL_EVB  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [SEL_W-1:0]   sel0;
    logic [SEL_W-1:0]   sel1;
    logic               exp_en;
    logic [NUM_CTR-1:0] ie;
    logic               div;
    logic               en;
  } ctrl_t;
endpackage

// File: rtl/pmu_ctrl_reg.sv
module pmu_ctrl_reg
  import pmu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wdata,
  output ctrl_t              ctrl_q,
  output logic               cyc_zero,
  output logic               evt_zero,
  output logic [NUM_CTR-1:0] flag_clr
);
  ctrl_t ctrl_d;
  logic  unused_bits;

  always_comb begin
    ctrl_d        = ctrl_q;
    ctrl_d.en     = wdata[B_EN];
    ctrl_d.div    = wdata[B_DIV];
    ctrl_d.ie     = wdata[B_IE +: NUM_CTR];
    ctrl_d.exp_en = wdata[B_EXP];
    ctrl_d.sel1   = wdata[B_SEL1 +: SEL_W];
    ctrl_d.sel0   = wdata[B_SEL0 +: SEL_W];
  end

  assign cyc_zero    = wr_en & wdata[B_CYRST];
  assign evt_zero    = wr_en & wdata[B_EVRST];
  // flags only clear while the stored enable is already set
  assign flag_clr    = (wr_en & ctrl_q.en) ? wdata[B_FLAG +: NUM_CTR] : '0;
  assign unused_bits = ^{wdata[DATA_W-1:B_SEL0+SEL_W], wdata[B_IE+NUM_CTR]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= ctrl_d;
  end
endmodule

// File: rtl/pmu_en_delay.sv
module pmu_en_delay #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES == 0) begin : g_none
      assign q = d;
    end else begin : g_pipe
      logic [STAGES-1:0] sh_q, sh_d;
      always_comb begin
        sh_d[0] = d;
        for (int i = 1; i < STAGES; i++) sh_d[i] = sh_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
      end
      assign q = sh_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         zero,
  input  logic         flag_clr,
  output logic [W-1:0] cnt_q,
  output logic         flag_q
);
  logic [W-1:0] cnt_d;
  logic         flag_d;
  logic         upd;

  always_comb begin
    cnt_d  = cnt_q;
    flag_d = flag_q & ~flag_clr;
    if (load)      cnt_d = load_val;
    else if (zero) cnt_d = '0;
    else if (inc) begin
      cnt_d = cnt_q + W'(1);
      if (&cnt_q) flag_d = 1'b1;
    end
  end

  assign upd = load | zero | inc | flag_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (upd) begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
  import pmu_pkg::*;
#(
  parameter int NUM_EVT = 16,
  parameter int EN_LAT  = 3,
  parameter int PRE_DIV = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic [1:0]         acc_sel,
  input  logic [DATA_W-1:0]  acc_wdata,
  input  logic               acc_priv,
  input  logic               user_ok,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               rsp_undef,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic               dbg_state,
  input  logic               dbg_permit,
  output logic [NUM_EVT-1:0] evt_bus,
  output logic               irq
);
  localparam int PRE_W = $clog2(PRE_DIV);
  localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(PRE_DIV - 1);
  localparam int DLY = (EN_LAT > 0) ? EN_LAT - 1 : 0;

  ctrl_t              ctrl_q;
  logic               glob_en, dly_en, count_on, evt_ok;
  logic               acc_ok, do_wr, cyc_zero, evt_zero;
  logic [NUM_CTR-1:0] flag_clr, flag_q, ctr_inc, ctr_load, ctr_zero;
  logic [DATA_W-1:0]  cnt_q [NUM_CTR];
  logic [PRE_W-1:0]   pre_q, pre_d;
  logic               tick, hit0, hit1;
  logic [DATA_W-1:0]  ctrl_rd, rd_val;
  logic               rsp_valid_d, rsp_undef_d;
  logic [DATA_W-1:0]  rsp_rdata_d;

  assign acc_ok = acc_priv | user_ok;
  assign do_wr  = acc_valid & acc_write & acc_ok;

  pmu_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(do_wr && acc_sel == SEL_CTRL),
    .wdata(acc_wdata), .ctrl_q(ctrl_q), .cyc_zero(cyc_zero),
    .evt_zero(evt_zero), .flag_clr(flag_clr)
  );

  assign glob_en = ctrl_q.en;

  pmu_en_delay #(.STAGES(DLY)) u_dly (
    .clk(clk), .rst_n(rst_n), .d(glob_en), .q(dly_en)
  );

  assign count_on = glob_en & dly_en;
  assign evt_ok   = ~dbg_state & dbg_permit;

  // cycle prescaler
  always_comb begin
    pre_d = pre_q;
    if (cyc_zero)                 pre_d = '0;
    else if (count_on & ctrl_q.div) pre_d = pre_q + PRE_W'(1);
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
  assign tick = ~ctrl_q.div | (pre_q == PRE_MAX);

  // event selection, out-of-range index selects nothing
  always_comb begin
    hit0 = 1'b0;
    hit1 = 1'b0;
    for (int k = 0; k < NUM_EVT; k++) begin
      if (ctrl_q.sel0 == SEL_W'(k)) hit0 = evt_in[k];
      if (ctrl_q.sel1 == SEL_W'(k)) hit1 = evt_in[k];
    end
  end

  assign ctr_inc  = {count_on & evt_ok & hit1, count_on & evt_ok & hit0, count_on & tick};
  assign ctr_zero = {evt_zero, evt_zero, cyc_zero};

  generate
    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
      assign ctr_load[i] = do_wr && (acc_sel == 2'(i + 1));
      pmu_counter #(.W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(ctr_inc[i]), .load(ctr_load[i]),
        .load_val(acc_wdata), .zero(ctr_zero[i]), .flag_clr(flag_clr[i]),
        .cnt_q(cnt_q[i]), .flag_q(flag_q[i])
      );
    end
  endgenerate

  assign irq     = |(flag_q & ctrl_q.ie);
  assign evt_bus = (ctrl_q.exp_en & ~dbg_state) ? evt_in : '0;

  always_comb begin
    ctrl_rd                     = '0;
    ctrl_rd[B_EN]               = ctrl_q.en;
    ctrl_rd[B_DIV]              = ctrl_q.div;
    ctrl_rd[B_IE +: NUM_CTR]    = ctrl_q.ie;
    ctrl_rd[B_FLAG +: NUM_CTR]  = flag_q;
    ctrl_rd[B_EXP]              = ctrl_q.exp_en;
    ctrl_rd[B_SEL1 +: SEL_W]    = ctrl_q.sel1;
    ctrl_rd[B_SEL0 +: SEL_W]    = ctrl_q.sel0;
  end

  always_comb begin
    if (acc_sel == SEL_CTRL) rd_val = ctrl_rd;
    else                     rd_val = cnt_q[acc_sel - 2'd1];
  end

  always_comb begin
    rsp_valid_d = acc_valid;
    rsp_undef_d = acc_valid & ~acc_ok;
    rsp_rdata_d = (acc_valid & acc_ok & ~acc_write) ? rd_val : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_undef <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rsp_valid_d;
      rsp_undef <= rsp_undef_d;
      rsp_rdata <= rsp_rdata_d;
    end
  end
endmodule

// File: rtl/pmu_checker.sv
module pmu_checker #(
  parameter int NUM_EVT = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               acc_valid,
  input logic               acc_priv,
  input logic               user_ok,
  input logic               rsp_valid,
  input logic               rsp_undef,
  input logic [31:0]        rsp_rdata,
  input logic               dbg_state,
  input logic [NUM_EVT-1:0] evt_bus,
  input logic               glob_en,
  input logic [2:0]         flags
);
  a_r11_user_refused: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_priv && !user_ok |=> rsp_valid && rsp_undef && rsp_rdata == 32'd0);

  a_r11_priv_granted: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_priv |=> rsp_valid && !rsp_undef);

  a_r2_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !rsp_valid);

  a_r10_debug_mask: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_state |-> evt_bus == '0);

  a_r9_clear_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    |($past(flags) & ~flags) |-> $past(glob_en));
endmodule

bind perf_mon_unit pmu_checker #(.NUM_EVT(NUM_EVT)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_priv(acc_priv),
  .user_ok(user_ok), .rsp_valid(rsp_valid), .rsp_undef(rsp_undef),
  .rsp_rdata(rsp_rdata), .dbg_state(dbg_state), .evt_bus(evt_bus),
  .glob_en(glob_en), .flags(flag_q)
);

// File: tb/tb_perf_mon_unit.sv
`timescale 1ns/1ps
module tb_perf_mon_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid, acc_write, acc_priv, user_ok;
  logic [1:0]  acc_sel;
  logic [31:0] acc_wdata;
  logic        rsp_valid, rsp_undef;
  logic [31:0] rsp_rdata;
  logic [15:0] evt_in, evt_bus;
  logic        dbg_state, dbg_permit, irq;

  perf_mon_unit dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_sel(acc_sel), .acc_wdata(acc_wdata), .acc_priv(acc_priv),
    .user_ok(user_ok), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_undef(rsp_undef), .evt_in(evt_in), .dbg_state(dbg_state),
    .dbg_permit(dbg_permit), .evt_bus(evt_bus), .irq(irq)
  );

  always #2 clk = ~clk;

  typedef struct {
    logic [31:0] data;
    logic        undef;
    bit          chk;
    string       req;
  } exp_t;

  exp_t        sb[$];
  int          nchk = 0, nbad = 0;
  bit          done = 0;
  logic [31:0] m_cyc = 0, m_ev0 = 0, m_ev1 = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: one request, expected response pushed to scoreboard
  task automatic acc(input bit wr, input logic [1:0] sel, input logic [31:0] wd, input bit priv,
                     input bit uok, input bit ck, input logic [31:0] ed, input bit eu, input string req);
    exp_t e;
    @(negedge clk);
    acc_valid = 1; acc_write = wr; acc_sel = sel; acc_wdata = wd; acc_priv = priv; user_ok = uok;
    e.data = ed; e.undef = eu; e.chk = ck; e.req = req;
    sb.push_back(e);
    @(negedge clk);
    acc_valid = 0; acc_write = 0;
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [31:0] wd);
    acc(1, sel, wd, 1, 0, 1, 32'd0, 0, "R2");
  endtask

  task automatic rd_chk(input logic [1:0] sel, input logic [31:0] exp, input string req);
    acc(0, sel, 0, 1, 0, 1, exp, 0, req);
  endtask

  task automatic run(input int m, input logic [31:0] base, input bit c, input bit e0, input bit e1);
    wr_reg(0, base | 32'd1);
    repeat (m) @(negedge clk);
    wr_reg(0, base);
    if (c)  m_cyc += 32'(m);
    if (e0) m_ev0 += 32'(m);
    if (e1) m_ev1 += 32'(m);
  endtask

  function automatic logic [31:0] bsel(input int s0, input int s1);
    return (32'(s0) << 20) | (32'(s1) << 12);
  endfunction

  // monitor: pops the scoreboard as responses appear
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && rsp_valid === 1'b1) begin
        if (sb.size() == 0) check(0, "R2 unexpected response", rsp_rdata, 32'd0);
        else begin
          exp_t e;
          e = sb.pop_front();
          if (e.chk) begin
            check(rsp_rdata === e.data, e.req, rsp_rdata, e.data);
            check(rsp_undef === e.undef, {e.req, " undef"}, 32'(rsp_undef), 32'(e.undef));
          end
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      nbad++; nchk++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  localparam logic [31:0] BASE9 = (32'd3 << 20) | (32'd5 << 12) | (32'd1 << 5);

  initial begin
    rst_n = 0; acc_valid = 0; acc_write = 0; acc_sel = 0; acc_wdata = 0;
    acc_priv = 0; user_ok = 0; evt_in = 0; dbg_state = 0; dbg_permit = 1;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(rsp_valid === 1'b0, "R1 rsp_valid", 32'(rsp_valid), 0);
    check(irq === 1'b0, "R1 irq", 32'(irq), 0);
    check(evt_bus === 16'd0, "R1 evt_bus", 32'(evt_bus), 0);
    for (int i = 0; i < 4; i++) rd_chk(2'(i), 32'd0, "R1 reg");

    // R3 enable latency
    run(0, 0, 1, 0, 0); rd_chk(1, m_cyc, "R3 window 0");
    run(1, 0, 1, 0, 0); rd_chk(1, m_cyc, "R3 window 1");
    run(10, 0, 1, 0, 0); rd_chk(1, m_cyc, "R3 window 10");

    // R12 write beats increment
    wr_reg(0, 1);
    repeat (5) @(negedge clk);
    wr_reg(1, 32'd100);
    wr_reg(0, 0);
    m_cyc = 32'd102;
    rd_chk(1, m_cyc, "R12 load priority");

    // R5 cycle clear, bits not stored
    wr_reg(0, 32'd1 << 2); m_cyc = 0;
    rd_chk(0, 32'd0, "R5 ctrl readback");
    rd_chk(1, 32'd0, "R5 cycle zeroed");

    // R4 divide by 64
    run(63, 32'd8, 0, 0, 0); rd_chk(1, 32'd0, "R4 63 edges");
    run(1, 32'd8, 0, 0, 0);  m_cyc = 1; rd_chk(1, m_cyc, "R4 64th edge");
    rd_chk(0, 32'd8, "R4 ctrl readback");

    // R6 event selection
    evt_in = 16'h0008;
    run(7, bsel(3, 5), 1, 1, 0);
    rd_chk(2, m_ev0, "R6 counter A"); rd_chk(3, m_ev1, "R6 counter B idle");
    evt_in = 16'h0020;
    run(4, bsel(200, 5), 1, 0, 1);
    rd_chk(2, m_ev0, "R6 out of range"); rd_chk(3, m_ev1, "R6 counter B");

    // R7 debug gating
    evt_in = 16'hFFFF; dbg_state = 1;
    run(5, bsel(3, 5), 1, 0, 0);
    rd_chk(2, m_ev0, "R7 debug A"); rd_chk(3, m_ev1, "R7 debug B"); rd_chk(1, m_cyc, "R7 cycle runs");
    dbg_state = 0; dbg_permit = 0;
    run(5, bsel(3, 5), 1, 0, 0);
    rd_chk(2, m_ev0, "R7 no permit A"); rd_chk(3, m_ev1, "R7 no permit B");
    dbg_permit = 1;

    // R5 event clear
    wr_reg(0, 32'd1 << 1); m_ev0 = 0; m_ev1 = 0;
    rd_chk(2, 0, "R5 A zeroed"); rd_chk(3, 0, "R5 B zeroed"); rd_chk(1, m_cyc, "R5 cycle kept");

    // R8 overflow
    wr_reg(2, 32'hFFFF_FFFE); m_ev0 = 32'hFFFF_FFFE;
    evt_in = 16'h0008;
    run(3, BASE9, 1, 1, 0);
    rd_chk(2, 32'd1, "R8 wrap");
    rd_chk(0, BASE9 | (32'd1 << 9), "R8 flag set");
    check(irq === 1'b1, "R8 irq on", 32'(irq), 1);
    wr_reg(0, bsel(3, 5));
    @(negedge clk);
    check(irq === 1'b0, "R8 irq masked", 32'(irq), 0);

    // R9 clear needs stored enable
    wr_reg(0, BASE9 | (32'd1 << 9));
    rd_chk(0, BASE9 | (32'd1 << 9), "R9 clear ignored");
    check(irq === 1'b1, "R9 irq kept", 32'(irq), 1);
    evt_in = 0;
    wr_reg(0, BASE9 | 32'd1);
    wr_reg(0, BASE9 | 32'd1 | (32'd1 << 9));
    wr_reg(0, BASE9);
    m_cyc += 2;
    rd_chk(0, BASE9, "R9 cleared");
    check(irq === 1'b0, "R9 irq off", 32'(irq), 0);
    rd_chk(1, m_cyc, "R3 short window");

    // R10 event mirror
    evt_in = 16'hA5C3;
    wr_reg(0, 32'd1 << 11);
    @(negedge clk);
    check(evt_bus === 16'hA5C3, "R10 export", 32'(evt_bus), 32'hA5C3);
    dbg_state = 1; #1;
    check(evt_bus === 16'd0, "R10 debug", 32'(evt_bus), 0);
    dbg_state = 0;
    wr_reg(0, 0);
    @(negedge clk);
    check(evt_bus === 16'd0, "R10 export off", 32'(evt_bus), 0);

    // R11 access checking
    acc(1, 1, 32'd55, 0, 0, 1, 32'd0, 1, "R11 user write refused");
    rd_chk(1, m_cyc, "R11 value kept");
    acc(0, 1, 0, 0, 0, 1, 32'd0, 1, "R11 user read refused");
    acc(1, 0, 32'd1, 0, 0, 1, 32'd0, 1, "R11 user ctrl refused");
    repeat (6) @(negedge clk);
    rd_chk(1, m_cyc, "R11 no counting started");
    acc(1, 1, 32'd55, 0, 1, 1, 32'd0, 0, "R11 user write allowed");
    acc(0, 1, 0, 0, 1, 1, 32'd55, 0, "R11 user read allowed");

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R2 all answered", 32'(sb.size()), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule